// File: doc/BRIEF.md
# Leading / Trailing Zero Counter

This block counts zero bits at one end of a 64-bit operand. A direction select chooses the end. When it is clear, counting starts at the most significant bit of the field and moves down. When it is set, counting starts at bit 0 and moves up. A span select chooses the field. The field is either the whole 64-bit operand or only its low 32-bit half, and in the half case the upper 32 bits are ignored.

The count is registered on the rising clock edge. It is driven zero-extended on a 64-bit result bus, so it can go straight onto a register-file write port.

When the chosen field holds no set bit, the count equals the field width: 64 for the full operand, 32 for the low half. This makes one unit serve four operations. A synchronous, active-high reset clears the result.

Top module: `zcnt_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count_q` becomes zero after that edge, whatever the other inputs are.
- R2: Inputs sampled at a rising edge determine `count_q` after that same edge, and `count_q` holds steady between edges.
- R3: With `trail_sel` = 0 and `word_sel` = 0, `count_q` is the number of zero bits from bit 63 downward before the first one, so an operand with bit 63 set gives 0.
- R4: With `trail_sel` = 1, `count_q` is the number of zero bits from bit 0 upward before the first one, so an operand with bit 0 set gives 0 in either span.
- R5: With `word_sel` = 0 and an all-zero operand, `count_q` is 64 for both values of `trail_sel`.
- R6: With `word_sel` = 1, bits 63..32 of `operand` have no effect on `count_q`.
- R7: With `word_sel` = 1 and bits 31..0 all zero, `count_q` is 32 for both directions. This includes a trailing count whose lowest set bit lies at bit 32 or above.
- R8: With `trail_sel` = 0 and `word_sel` = 1, counting starts at bit 31, so an operand with bit 31 set gives 0.
- R9: The count occupies bits 6..0 of `count_q`, and bits 63..7 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| operand | input | 64 | Value to be scanned |
| trail_sel | input | 1 | 0 = count from the top of the field, 1 = count from bit 0 |
| word_sel | input | 1 | 0 = scan all 64 bits, 1 = scan bits 31..0 only |
| count_q | output | 64 | Registered zero count, zero-extended |

## Verification
Direction and span can change in the same cycle as the operand. The low-half field then needs both the mirror and the sentinel at once. The bench applies vectors back to back, so consecutive cycles flip `trail_sel` and `word_sel` together while the operand also changes. Each result is compared, one edge later, with a count the bench derives from the requirements. A trailing scan in half span with the lowest one at bit 32 or above exercises both paths together and must give exactly 32.

// File: rtl/zcnt_pkg.sv
package zcnt_pkg;

    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;
    localparam int LEVELS = $clog2(DATA_W);
    localparam int CNT_W  = LEVELS + 1;

    typedef enum logic {
        SCAN_FROM_TOP    = 1'b0,
        SCAN_FROM_BOTTOM = 1'b1
    } scan_dir_e;

    typedef enum logic {
        SPAN_FULL = 1'b0,
        SPAN_HALF = 1'b1
    } scan_span_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        scan_dir_e         dir;
        scan_span_e        span;
    } scan_req_t;

    function automatic logic [DATA_W-1:0] mirror_full(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = v[DATA_W-1-i];
        end
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] mirror_half(input logic [HALF_W-1:0] v);
        logic [HALF_W-1:0] r;
        for (int i = 0; i < HALF_W; i++) begin
            r[i] = v[HALF_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/zcnt_align.sv
module zcnt_align
    import zcnt_pkg::*;
(
    input  scan_req_t         req,
    output logic [DATA_W-1:0] tree_in
);

    localparam int PAD_W = DATA_W - HALF_W - 1;

    logic [HALF_W-1:0] low_field;
    logic [HALF_W-1:0] low_oriented;

    assign low_field = req.value[HALF_W-1:0];

    always_comb begin
        if (req.dir == SCAN_FROM_BOTTOM) begin
            low_oriented = mirror_half(low_field);
        end else begin
            low_oriented = low_field;
        end
    end

    // Half span: the oriented field sits at the top, followed by a one
    // that stops the count at HALF_W when the field is empty.
    always_comb begin
        if (req.span == SPAN_HALF) begin
            tree_in = {low_oriented, 1'b1, {PAD_W{1'b0}}};
        end else if (req.dir == SCAN_FROM_BOTTOM) begin
            tree_in = mirror_full(req.value);
        end else begin
            tree_in = req.value;
        end
    end

endmodule

// File: rtl/zcnt_lz_tree.sv
module zcnt_lz_tree #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);

    localparam int LV = $clog2(W);

    // Node n of level l covers 2**l bits, node 0 being the most
    // significant. Its count equals 2**l exactly when its bits are all zero.
    for (genvar l = 0; l <= LV; l++) begin : g_lvl
        localparam int NODES = W >> l;
        logic [CW-1:0] cnt [NODES];

        for (genvar n = 0; n < NODES; n++) begin : g_node
            if (l == 0) begin : g_leaf
                assign cnt[n] = vec[W-1-n] ? '0 : CW'(1);
            end else begin : g_join
                localparam logic [CW-1:0] CHILD_SPAN = CW'(1) << (l - 1);
                logic          left_empty;
                logic [CW-1:0] left_cnt;
                logic [CW-1:0] right_cnt;

                assign left_cnt   = g_lvl[l-1].cnt[2*n];
                assign right_cnt  = g_lvl[l-1].cnt[2*n+1];
                assign left_empty = (left_cnt == CHILD_SPAN);
                assign cnt[n]     = left_empty ? (CHILD_SPAN + right_cnt) : left_cnt;
            end
        end
    end

    assign zeros = g_lvl[LV].cnt[0];

endmodule

// File: rtl/zcnt_hold.sv
module zcnt_hold #(
    parameter int CW  = 7,
    parameter int OUT = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CW-1:0]  d,
    output logic [OUT-1:0] q
);

    logic [CW-1:0] cnt_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_r <= '0;
        end else begin
            cnt_r <= d;
        end
    end

    assign q = OUT'(cnt_r);

endmodule

// File: rtl/zcnt_unit.sv
module zcnt_unit
    import zcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] operand,
    input  logic              trail_sel,
    input  logic              word_sel,
    output logic [DATA_W-1:0] count_q
);

    scan_req_t         req;
    logic [DATA_W-1:0] tree_in;
    logic [CNT_W-1:0]  zeros;

    assign req.value = operand;
    assign req.dir   = scan_dir_e'(trail_sel);
    assign req.span  = scan_span_e'(word_sel);

    zcnt_align u_align (
        .req     (req),
        .tree_in (tree_in)
    );

    zcnt_lz_tree #(
        .W  (DATA_W),
        .CW (CNT_W)
    ) u_tree (
        .vec   (tree_in),
        .zeros (zeros)
    );

    zcnt_hold #(
        .CW  (CNT_W),
        .OUT (DATA_W)
    ) u_hold (
        .clk (clk),
        .rst (rst),
        .d   (zeros),
        .q   (count_q)
    );

endmodule

// File: rtl/zcnt_unit_chk.sv
module zcnt_unit_chk
    import zcnt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] operand,
    input logic              trail_sel,
    input logic              word_sel,
    input logic [DATA_W-1:0] count_q
);

    assert_upper_clear_R9: assert property (@(posedge clk) disable iff (rst)
        count_q[DATA_W-1:CNT_W] == '0);

    assert_full_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(word_sel) && $past(operand) == '0)
        |-> count_q == DATA_W);

    assert_half_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(word_sel) && $past(operand[HALF_W-1:0]) == '0)
        |-> count_q == HALF_W);

    assert_half_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(word_sel)) |-> count_q <= HALF_W);

    assert_top_set_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(trail_sel) && !$past(word_sel) && $past(operand[DATA_W-1]))
        |-> count_q == '0);

    assert_half_top_set_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(trail_sel) && $past(word_sel) && $past(operand[HALF_W-1]))
        |-> count_q == '0);

    assert_bottom_set_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(trail_sel) && $past(operand[0]))
        |-> count_q == '0);

endmodule

bind zcnt_unit zcnt_unit_chk u_chk (.*);

// File: tb/zcnt_unit_bench.sv
module zcnt_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] operand;
    logic        trail_sel;
    logic        word_sel;
    logic [63:0] count_q;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    zcnt_unit u_zcnt_unit (
        .clk       (clk),
        .rst       (rst),
        .operand   (operand),
        .trail_sel (trail_sel),
        .word_sel  (word_sel),
        .count_q   (count_q)
    );

    typedef struct packed {
        logic [63:0] op;
        logic        tr;
        logic        wd;
        logic [6:0]  exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0000_0000, 1'b0, 1'b0, 7'd64},
        '{64'h0000_0000_0000_0000, 1'b1, 1'b0, 7'd64},
        '{64'h0000_0000_0000_0000, 1'b0, 1'b1, 7'd32},
        '{64'h0000_0000_0000_0000, 1'b1, 1'b1, 7'd32},
        '{64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, 7'd32},
        '{64'h8000_0000_0000_0000, 1'b0, 1'b0, 7'd0},
        '{64'h0000_0000_0000_0001, 1'b1, 1'b0, 7'd0},
        '{64'h0000_0000_0000_0001, 1'b0, 1'b0, 7'd63},
        '{64'h8000_0000_0000_0000, 1'b1, 1'b0, 7'd63},
        '{64'h0000_0001_0000_0000, 1'b1, 1'b1, 7'd32},
        '{64'hDEAD_BEEF_8000_0000, 1'b0, 1'b1, 7'd0},
        '{64'h1234_0000_0001_0000, 1'b0, 1'b1, 7'd15},
        '{64'h0000_0000_00F0_0000, 1'b1, 1'b0, 7'd20}
    };

    function automatic string tag_for(input logic [63:0] op, input logic tr, input logic wd);
        if (wd) return (op[31:0] == '0) ? "R7" : (tr ? "R4" : "R8");
        if (op == '0) return "R5";
        return tr ? "R4" : "R3";
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [63:0] op, input logic tr, input logic wd);
        operand   = op;
        trail_sel = tr;
        word_sel  = wd;
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        apply(64'h0000_0000_0000_0001, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("R1", count_q, 64'd0);

        // Table walk, one vector per cycle.
        @(negedge clk);
        rst = 1'b0;
        apply(VECS[0].op, VECS[0].tr, VECS[0].wd);
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            check(tag_for(VECS[k].op, VECS[k].tr, VECS[k].wd), count_q, 64'(VECS[k].exp));
            check("R9", count_q >> 7, 64'd0);
            if (k + 1 < NV) apply(VECS[k+1].op, VECS[k+1].tr, VECS[k+1].wd);
        end

        // R2: output only moves at the edge.
        apply(64'h0000_0000_0000_0000, 1'b0, 1'b0);
        @(negedge clk);
        check("R2", count_q, 64'd64);
        apply(64'h8000_0000_0000_0000, 1'b0, 1'b0);
        #1;
        check("R2", count_q, 64'd64);
        @(negedge clk);
        check("R2", count_q, 64'd0);

        // R3: full leading sweep, random bits below the leading one.
        for (int i = 0; i < 64; i++) begin
            logic [63:0] below;
            below = (64'h1 << (63 - i)) - 64'h1;
            apply((64'h8000_0000_0000_0000 >> i) | (rnd64() & below), 1'b0, 1'b0);
            @(negedge clk);
            check("R3", count_q, 64'(i));
        end

        // R8 and R6: half leading sweep with random upper half.
        for (int i = 0; i < 32; i++) begin
            logic [31:0] below;
            logic [31:0] lo;
            below = (32'h1 << (31 - i)) - 32'h1;
            lo    = (32'h8000_0000 >> i) | ($urandom() & below);
            apply({$urandom(), lo}, 1'b0, 1'b1);
            @(negedge clk);
            check("R8", count_q, 64'(i));
        end

        // R4 and R7: trailing sweeps in both spans, random bits above.
        for (int i = 0; i < 64; i++) begin
            logic [63:0] above;
            logic [63:0] op;
            above = ~((64'h1 << (i + 1)) - 64'h1);
            op    = (64'h1 << i) | (rnd64() & above);
            apply(op, 1'b1, 1'b0);
            @(negedge clk);
            check("R4", count_q, 64'(i));
            apply(op, 1'b1, 1'b1);
            @(negedge clk);
            if (i < 32) check("R4", count_q, 64'(i));
            else        check("R7", count_q, 64'd32);
        end

        // R6: same low half, different upper halves, both directions.
        for (int j = 0; j < 8; j++) begin
            logic [31:0] lo;
            lo = 32'h0001_0000 << (j % 4);
            apply({32'h0000_0000, lo}, j[0], 1'b1);
            @(negedge clk);
            check("R6", count_q, j[0] ? 64'(16 + j % 4) : 64'(15 - j % 4));
            apply({32'hFFFF_FFFF, lo}, j[0], 1'b1);
            @(negedge clk);
            check("R6", count_q, j[0] ? 64'(16 + j % 4) : 64'(15 - j % 4));
        end

        // R1 again: reset mid-run with a nonzero count pending.
        apply(64'h0000_0000_0000_0001, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check("R1", count_q, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R3", count_q, 64'd63);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule